// File: doc/BRIEF.md
# SPI command front end for a CAN controller register file

This block is the serial side of a CAN controller. A host talks to it over SPI mode 0 (clock idles low, data sampled on the rising edge, shifted on the falling edge). Each transaction starts when chip select falls. The first byte is an instruction and the bytes after it are address and data. The instructions act on a 128-byte register file. They are:

- reset
- streamed read and write
- masked bit update
- request-to-send
- two shortcut instructions that preset the address pointer into a transmit or receive buffer

The SPI pins are brought into the system clock domain through synchronizer stages, and all decoding runs on the system clock. Receive buffers are filled from a parallel side port, which is where the CAN engine connects. That engine also raises the buffer-full flag through the side port. Three transmit-request outputs come from control bits in the register file. An active-low interrupt output combines the flag register with the enable register.

Top module: `canspi_cmd_core`

## Requirements
- R1: After the reset input is asserted: the control register at 0x0F reads 0x80; the status register at 0x0E reads 0x80 (mode bits 7:5 = 100, configuration); int_n is 1; txreq is 000.
- R2: Instruction 0x02 (write) takes an address byte, then stores each following data byte at the pointer. Instruction 0x03 (read) takes an address byte, then returns the byte at the pointer MSB first on miso. In both cases the 7-bit pointer increments, and wraps, after every byte for as long as cs_n stays low.
- R3: Instruction 0x05 takes address, mask and data bytes. It sets the register to (old & ~mask) | (data & mask).
- R4: Instruction 0x40|c (c = 0..5) writes streamed data starting at 0x31, 0x36, 0x41, 0x46, 0x51 and 0x56 respectively. For c = 6 or 7 the transaction is ignored and no register changes.
- R5: Instruction 0x90|(c<<1) (c = 0..3) streams read data on miso from the byte right after the instruction. It starts at 0x61, 0x66, 0x71 and 0x76 respectively.
- R6: When cs_n rises after an instruction 0x90|(c<<1), the flag register at 0x2C has its bit cleared: bit 0 when c is 0 or 1, bit 1 when c is 2 or 3.
- R7: Instruction 0x80|m sets bit 3 of 0x30, 0x40 and 0x50 for m bits 0, 1 and 2 respectively. Several bits may be set in one instruction. txreq[i] equals bit 3 of the register at 0x30 + 16*i.
- R8: The flag register 0x2C holds six flags in bits 5:0: receive 0, receive 1, transmit 0, transmit 1, transmit 2 and error. int_n is 0 exactly when some bit in 5:0 is 1 in both 0x2C and the enable register 0x2B.
- R9: Instruction 0xC0 returns every register to its reset value, giving the same port state as R1. Mode bits 7:5 read from 0x0E always equal bits 7:5 of 0x0F.
- R10: miso is high-impedance while cs_n is high.
- R11: If cs_n rises part way through a byte, the partial byte is discarded and no register changes. An unknown instruction byte causes every following byte to be ignored until cs_n rises.
- R12: A side-port write (rxw_en) stores rxw_data at 0x61 + rxw_ofs for buffer 0 and at 0x71 + rxw_ofs for buffer 1. A pulse on rx_post sets bit rxw_buf of 0x2C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI clock, mode 0 |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data from host |
| miso | output | 1 | SPI data to host, high-impedance while deselected |
| txreq | output | 3 | Transmit request per transmit buffer |
| int_n | output | 1 | Active-low interrupt |
| rxw_en | input | 1 | Side-port receive buffer byte write |
| rxw_buf | input | 1 | Side-port receive buffer select |
| rxw_ofs | input | 4 | Byte offset inside the receive buffer |
| rxw_data | input | 8 | Side-port write data |
| rx_post | input | 1 | Set the receive-full flag of buffer rxw_buf |

## Verification
The bench builds the block with the default parameters: SYNC_N = 2 synchronizer stages and a 7-bit address. The SPI half period is 8 system clocks. That margin lets the pointer reload on a falling edge reach miso before the next rising edge. It also covers the step from address byte to first read byte and from one streamed byte to the next. With the full 128-byte map addressable, random bursts reach pointer wrap and the status mode mirror, as well as the transmit control and interrupt registers.

// File: rtl/canspi_cmd_core.sv
module canspi_cmd_core #(
  parameter int SYNC_N = 2,
  parameter int AW     = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       miso,
  output logic [2:0] txreq,
  output logic       int_n,
  input  logic       rxw_en,
  input  logic       rxw_buf,
  input  logic [3:0] rxw_ofs,
  input  logic [7:0] rxw_data,
  input  logic       rx_post
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] A_STAT = AW'(8'h0E);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h0F);
  localparam logic [AW-1:0] A_IEN  = AW'(8'h2B);
  localparam logic [AW-1:0] A_IFL  = AW'(8'h2C);
  localparam logic [AW-1:0] A_TXC  = AW'(8'h30);
  localparam logic [AW-1:0] A_TXB  = AW'(8'h31);
  localparam logic [AW-1:0] A_RXB  = AW'(8'h61);
  localparam logic [7:0]    CTRL_RST = 8'h80;

  typedef enum logic [2:0] {P_OP, P_AD, P_WR, P_RD, P_MK, P_BD, P_IG} phase_t;
  typedef enum logic [1:0] {K_RD, K_WR, K_BM} kind_t;

  logic [SYNC_N-1:0] sck_sh, cs_sh, mo_sh;
  logic sck_d, cs_d;
  logic sck_s, cs_s, mo_s;
  logic sck_rise, sck_fall, cs_rise, byte_done;

  phase_t phase;
  kind_t  kind;
  logic [2:0]    bitcnt;
  logic [7:0]    shin, txsh, mask;
  logic [AW-1:0] ptr;
  logic [1:0]    rxpend;
  logic [7:0]    mem [DEPTH];

  logic [7:0]    byte_in, rd_byte, spi_wd;
  logic          spi_we, soft_rst, rts_fire;
  logic [2:0]    rts_mask;
  logic [AW-1:0] rx_addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_sh <= '0;
      cs_sh  <= '1;
      mo_sh  <= '0;
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sck_sh <= {sck_sh[SYNC_N-2:0], sck};
      cs_sh  <= {cs_sh[SYNC_N-2:0], cs_n};
      mo_sh  <= {mo_sh[SYNC_N-2:0], mosi};
      sck_d  <= sck_s;
      cs_d   <= cs_s;
    end

  assign sck_s     = sck_sh[SYNC_N-1];
  assign cs_s      = cs_sh[SYNC_N-1];
  assign mo_s      = mo_sh[SYNC_N-1];
  assign sck_rise  = sck_s & ~sck_d & ~cs_s;
  assign sck_fall  = ~sck_s & sck_d & ~cs_s;
  assign cs_rise   = cs_s & ~cs_d;
  assign byte_in   = {shin[6:0], mo_s};
  assign byte_done = sck_rise && (bitcnt == 3'd7);

  assign soft_rst = byte_done && (phase == P_OP) && (byte_in == 8'hC0);
  assign rts_fire = byte_done && (phase == P_OP) && (byte_in[7:3] == 5'b10000);
  assign rts_mask = byte_in[2:0];
  assign spi_we   = byte_done && ((phase == P_WR) || (phase == P_BD));
  assign spi_wd   = (phase == P_BD) ? ((mem[ptr] & ~mask) | (byte_in & mask)) : byte_in;
  assign rd_byte  = (ptr == A_STAT) ? {mem[A_CTRL][7:5], mem[A_STAT][4:0]} : mem[ptr];
  assign rx_addr  = A_RXB + AW'({rxw_buf, 4'h0}) + AW'(rxw_ofs);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase  <= P_OP;
      kind   <= K_RD;
      bitcnt <= '0;
      shin   <= '0;
      mask   <= '0;
      ptr    <= '0;
      rxpend <= '0;
      txsh   <= '0;
    end else if (cs_s) begin
      phase  <= P_OP;
      bitcnt <= '0;
      rxpend <= '0;
    end else begin
      if (sck_fall && phase == P_RD)
        txsh <= (bitcnt == 3'd0) ? rd_byte : {txsh[6:0], 1'b0};
      if (sck_rise) begin
        bitcnt <= bitcnt + 3'd1;
        shin   <= byte_in;
      end
      if (byte_done)
        unique case (phase)
          P_OP: casez (byte_in)
            8'h03: begin kind <= K_RD; phase <= P_AD; end
            8'h02: begin kind <= K_WR; phase <= P_AD; end
            8'h05: begin kind <= K_BM; phase <= P_AD; end
            8'b0100_0???:
              if (byte_in[2:0] < 3'd6) begin
                ptr   <= A_TXB + AW'({byte_in[2:1], 4'h0}) + (byte_in[0] ? AW'(5) : AW'(0));
                phase <= P_WR;
              end else phase <= P_IG;
            8'b1001_0??0: begin
              ptr   <= A_RXB + AW'({byte_in[2], 4'h0}) + (byte_in[1] ? AW'(5) : AW'(0));
              rxpend[byte_in[2]] <= 1'b1;
              phase <= P_RD;
            end
            default: phase <= P_IG;
          endcase
          P_AD: begin
            ptr   <= byte_in[AW-1:0];
            phase <= (kind == K_RD) ? P_RD : (kind == K_WR) ? P_WR : P_MK;
          end
          P_WR, P_RD: ptr <= ptr + AW'(1);
          P_MK: begin mask <= byte_in; phase <= P_BD; end
          default: phase <= P_IG;
        endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= (i == int'(A_CTRL)) ? CTRL_RST : 8'h00;
    end else if (soft_rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= (i == int'(A_CTRL)) ? CTRL_RST : 8'h00;
    end else begin
      if (rxw_en) mem[rx_addr] <= rxw_data;
      if (spi_we) mem[ptr] <= spi_wd;
      if (rts_fire)
        for (int i = 0; i < 3; i++)
          if (rts_mask[i]) mem[A_TXC + AW'(16 * i)][3] <= 1'b1;
      if (cs_rise)
        for (int b = 0; b < 2; b++)
          if (rxpend[b]) mem[A_IFL][b] <= 1'b0;
      if (rx_post) mem[A_IFL][rxw_buf] <= 1'b1;
    end

  generate
    for (genvar g = 0; g < 3; g++) begin : g_txreq
      assign txreq[g] = mem[A_TXC + AW'(16 * g)][3];
    end
  endgenerate

  assign int_n = ~|(mem[A_IEN] & mem[A_IFL] & 8'h3F);
  assign miso  = cs_n ? 1'bz : txsh[7];

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !cs_s && (phase == P_WR || phase == P_RD)) |=> (ptr == AW'($past(ptr) + AW'(1)))); // R2
  AST_RTS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rts_fire |=> ((txreq & $past(rts_mask)) == $past(rts_mask))); // R7
  AST_RX_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && rxpend[0] && !(rx_post && !rxw_buf)) |=> !mem[A_IFL][0]); // R6
  AST_INT_ON_POST: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_post && mem[A_IEN][rxw_buf] && !spi_we && !soft_rst) |=> !int_n); // R8
  AST_CFG_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (mem[A_CTRL][7:5] == 3'b100 && txreq == 3'b000 && int_n)); // R9
endmodule

// File: tb/test_canspi_cmd_core.sv
module test_canspi_cmd_core;
  localparam int H = 8;
  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, mosi = 0;
  logic rxw_en = 0, rxw_buf = 0, rx_post = 0;
  logic [3:0] rxw_ofs = 0;
  logic [7:0] rxw_data = 0;
  wire  miso;
  logic [2:0] txreq;
  logic int_n;
  int checks = 0, errors = 0;
  logic done = 0;
  logic [7:0] m [128];
  logic [7:0] wb [16];
  logic [7:0] r;

  canspi_cmd_core i_canspi_cmd_core (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .txreq(txreq), .int_n(int_n), .rxw_en(rxw_en), .rxw_buf(rxw_buf),
    .rxw_ofs(rxw_ofs), .rxw_data(rxw_data), .rx_post(rx_post));

  always #4 clk = ~clk;

  function automatic logic [7:0] mr(input logic [6:0] a);
    return (a == 7'h0E) ? {m[7'h0F][7:5], m[7'h0E][4:0]} : m[a];
  endfunction
  function automatic logic exp_int();
    return ~|(m[7'h2B] & m[7'h2C] & 8'h3F);
  endfunction
  function automatic logic [2:0] exp_tx();
    return {m[7'h50][3], m[7'h40][3], m[7'h30][3]};
  endfunction

  task automatic mreset();
    for (int i = 0; i < 128; i++) m[i] = (i == 15) ? 8'h80 : 8'h00;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbeg(); cyc(1); cs_n = 0; cyc(H); endtask
  task automatic send(); cyc(H); cs_n = 1; cyc(8); endtask

  task automatic xfer(input logic [7:0] t, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = t[i];
      cyc(H);
      sck = 1;
      rx[i] = miso;
      cyc(H);
      sck = 0;
    end
  endtask

  task automatic wr(input logic [6:0] a, input int n);
    logic [7:0] d;
    sbeg(); xfer(8'h02, d); xfer({1'b0, a}, d);
    for (int i = 0; i < n; i++) begin xfer(wb[i], d); m[7'(a + i)] = wb[i]; end
    send();
  endtask

  task automatic rdchk(input string tag, input logic [6:0] a, input int n);
    logic [7:0] d;
    sbeg(); xfer(8'h03, d); xfer({1'b0, a}, d);
    for (int i = 0; i < n; i++) begin xfer(8'h00, d); chk(tag, d, mr(7'(a + i))); end
    send();
  endtask

  task automatic bm(input logic [6:0] a, input logic [7:0] k, input logic [7:0] v);
    logic [7:0] d;
    sbeg(); xfer(8'h05, d); xfer({1'b0, a}, d); xfer(k, d); xfer(v, d); send();
    m[a] = (m[a] & ~k) | (v & k);
  endtask

  task automatic ports(input string tag);
    chk({tag, " int_n"}, {7'd0, int_n}, {7'd0, exp_int()});
    chk({tag, " txreq"}, {5'd0, txreq}, {5'd0, exp_tx()});
  endtask

  task automatic side(input logic b, input logic [3:0] o, input logic [7:0] v);
    @(negedge clk); rxw_en = 1; rxw_buf = b; rxw_ofs = o; rxw_data = v;
    @(negedge clk); rxw_en = 0;
    m[7'h61 + {2'b0, b, 4'h0} + {3'b0, o}] = v;
  endtask

  task automatic post(input logic b);
    @(negedge clk); rx_post = 1; rxw_buf = b;
    @(negedge clk); rx_post = 0;
    m[7'h2C][b] = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240611));
    mreset();
    cyc(4); rst_n = 1; cyc(4);
    // R1 reset state, R10 hi-Z
    chk("R1 int_n", {7'd0, int_n}, 8'd1);
    chk("R1 txreq", {5'd0, txreq}, 8'd0);
    chk("R10 miso hiz", {7'd0, miso === 1'bz}, 8'd1);
    rdchk("R1 stat/ctrl", 7'h0E, 2);

    // R2 burst and wrap
    for (int i = 0; i < 4; i++) wb[i] = 8'hA0 + 8'(i);
    wr(7'h20, 4); rdchk("R2 burst", 7'h20, 4);
    wb[0] = 8'h5A; wb[1] = 8'hC3; wr(7'h7F, 2); rdchk("R2 wrap", 7'h7F, 2);

    // random mix, R2 R3 R7 R8 R9
    for (int it = 0; it < 30; it++) begin
      logic [6:0] a;
      int n;
      a = 7'($urandom);
      n = 1 + int'($urandom % 4);
      if ($urandom % 3 == 0) bm(a, 8'($urandom), 8'($urandom));
      else begin
        for (int i = 0; i < n; i++) wb[i] = 8'($urandom);
        wr(a, n);
      end
      rdchk("R2 random", a, n);
      ports("R8 R7 random");
    end

    // R9 soft reset, mode mirror
    wb[0] = 8'h47; wr(7'h0F, 1); rdchk("R9 mode mirror", 7'h0E, 1);
    sbeg(); xfer(8'hC0, d); send(); mreset();
    rdchk("R9 after reset", 7'h0E, 2);
    ports("R9 ports");

    // R3 directed
    wb[0] = 8'hF0; wr(7'h25, 1);
    bm(7'h25, 8'h3C, 8'hAA);
    chk("R3 model", m[7'h25], 8'hE8);
    rdchk("R3 bitmod", 7'h25, 1);

    // R4 load transmit buffer
    for (int c = 0; c < 8; c++) begin
      logic [6:0] base;
      base = 7'h31 + 7'((c / 2) * 16) + ((c % 2) ? 7'd5 : 7'd0);
      sbeg(); xfer(8'h40 | 8'(c), d);
      for (int i = 0; i < 3; i++) begin
        wb[i] = 8'($urandom);
        xfer(wb[i], d);
        if (c < 6) m[7'(base + i)] = wb[i];
      end
      send();
    end
    rdchk("R4 tx shortcut", 7'h31, 8); rdchk("R4 tx shortcut", 7'h41, 8);
    rdchk("R4 tx shortcut", 7'h51, 8); rdchk("R4 code67 ignored", 7'h60, 4);
    rdchk("R4 code67 ignored", 7'h00, 4);

    // R7 request-to-send
    wb[0] = 0; wr(7'h30, 1); wr(7'h40, 1); wr(7'h50, 1);
    ports("R7 cleared");
    sbeg(); xfer(8'h85, d); send(); m[7'h30][3] = 1; m[7'h50][3] = 1;
    ports("R7 mask5");
    sbeg(); xfer(8'h82, d); send(); m[7'h40][3] = 1;
    ports("R7 mask2");

    // R12 R5 R6 R8 receive path
    wb[0] = 8'h03; wr(7'h2B, 1); wb[0] = 8'h00; wr(7'h2C, 1);
    for (int i = 0; i < 13; i++) begin side(0, 4'(i), 8'($urandom)); side(1, 4'(i), 8'($urandom)); end
    post(1); cyc(2);
    ports("R8 R12 post1");
    for (int c = 0; c < 4; c++) begin
      logic [6:0] base;
      base = 7'h61 + 7'((c / 2) * 16) + ((c % 2) ? 7'd5 : 7'd0);
      if (c == 0) post(0);
      sbeg(); xfer(8'h90 | 8'(c << 1), d);
      for (int i = 0; i < 5; i++) begin xfer(8'h00, d); chk("R5 rx shortcut", d, m[7'(base + i)]); end
      send(); m[7'h2C][c / 2] = 1'b0;
      rdchk("R6 flag clear", 7'h2C, 1);
      ports("R6 R8 after read");
    end

    // R11 abort and unknown opcode
    wb[0] = 8'h11; wr(7'h12, 1);
    sbeg(); xfer(8'h02, d); xfer(8'h12, d);
    for (int i = 7; i >= 4; i--) begin mosi = 1'b1; cyc(H); sck = 1; cyc(H); sck = 0; end
    send();
    rdchk("R11 abort", 7'h12, 1);
    sbeg(); xfer(8'h11, d); xfer(8'h02, d); xfer(8'h12, d); xfer(8'hEE, d); send();
    rdchk("R11 unknown", 7'h12, 1);
    chk("R10 miso hiz end", {7'd0, miso === 1'bz}, 8'd1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule